// File: doc/BRIEF.md
# Four-Phase Memory Bus Cycle Sequencer

This block sits between a synchronous requester and an asynchronous, word-addressed memory of 1024 sixteen-bit words. A request for a read or a write is presented for a single clock cycle. The block turns it into a bus cycle of fixed length. During that cycle the address, the memory enable, the read/write select and the write data are driven in a set order of phases, and at the end of the last phase the word that was read is captured.

The number of phases comes from the clock period and from the slower of the memory's access and write times, rounded up to whole clocks. With a 20 ns clock, a 65 ns access time and a 75 ns write time, this gives four phases (T1 to T4). The address and enable go out in T1. The read/write select, and for a write the data, change only from T2 onward, so the address is settled before the memory sees a write strobe. While a cycle is running the block reports busy and does not accept new requests. The cycle after the last phase carries a one-cycle done pulse, together with the captured word for a read.

Top module: `mem_cycle_seq`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `busy`=0, `done`=0, `mem_en`=0, `mem_rw`=1 and `rd_data`=0.
- R2: A request is accepted only on a clock edge where `req_valid`=1 and `req_ready`=1. While a cycle runs, `req_ready`=0 and `busy`=1, and a request presented then is ignored: the bus address does not change and no extra done pulse appears.
- R3: In the first phase (T1), `mem_en`=1, `mem_addr` carries the accepted address, `mem_rw`=1 and `mem_wdata`=0, for reads and writes alike.
- R4: For a write, `mem_rw`=0 (0 means write) and `mem_wdata` carries the accepted data from T2 through the last phase, and not before.
- R5: For a read, `mem_rw`=1 through every phase, and `rd_data` takes the value of `mem_rdata` sampled on the clock edge that ends the last phase.
- R6: The address, the read/write select and the write data stay constant from T2 to the end of the cycle, whatever the request inputs do meanwhile.
- R7: `done` is high for exactly one cycle, namely the cycle right after the last phase. A write leaves `rd_data` unchanged.
- R8: The number of phases N equals ceil(max(access time, write time) / clock period). With the defaults (20 ns, 65 ns, 75 ns) this is 4, and `mem_en` stays high for exactly N consecutive cycles for each request.
- R9: While idle, `mem_en`=0, `mem_rw`=1 and `mem_wdata`=0, so the memory cannot see a write outside a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 10 | Word address of the request |
| req_wdata | input | 16 | Data for a write |
| req_ready | output | 1 | High when a request can be accepted |
| busy | output | 1 | High while a bus cycle runs |
| done | output | 1 | One-cycle pulse after the last phase |
| rd_data | output | 16 | Word captured by the last read |
| mem_addr | output | 10 | Address lines toward the memory |
| mem_en | output | 1 | Memory enable, active high |
| mem_rw | output | 1 | Read/write select, 1 = read, 0 = write |
| mem_wdata | output | 16 | Data lines toward the memory for a write |
| mem_rdata | input | 16 | Data lines from the memory |

## Verification
The assertions assume that the memory's read data is valid on the edge that ends the last phase and that the requester respects `req_ready`. They also assume that reset is applied before the first request. The stimulus only ever relies on handshakes at `req_ready`. It deliberately holds `req_valid` high during a running cycle, with a different address and a write, and drops it before the block returns to idle, so that the stray request can never be legally accepted. The behavioural memory returns a marker word until its read delay has elapsed and commits a write only when the write strobe has been held into the last phase. Early capture or a shortened cycle therefore shows up as wrong data.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  // Integer ceiling division for positive operands.
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Clocks per bus cycle: the slower memory timing over the clock period.
  function automatic int phase_count(input int period_ns, input int access_ns,
                                     input int write_ns);
    int slowest;
    slowest = (access_ns > write_ns) ? access_ns : write_ns;
    return ceil_div(slowest, period_ns);
  endfunction

endpackage

// File: rtl/mcs_phase_ctrl.sv
module mcs_phase_ctrl #(
  parameter int NUM_PHASES = 4,
  localparam int PW = $clog2(NUM_PHASES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  output logic [PW-1:0] phase,
  output logic          phase_first,
  output logic          phase_last,
  output logic          active
);

  localparam logic [PW-1:0] LAST = PW'(NUM_PHASES);

  // phase 0 is idle; 1..NUM_PHASES are T1..TN
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (accept) begin
      phase <= PW'(1);
    end else if (phase == LAST) begin
      phase <= '0;
    end else if (phase != '0) begin
      phase <= phase + PW'(1);
    end
  end

  assign active      = (phase != '0);
  assign phase_first = (phase == PW'(1));
  assign phase_last  = (phase == LAST);

  assert_phase_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST);

  assert_phase_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !phase_last) |=> (phase == $past(phase) + PW'(1)));

endmodule

// File: rtl/mcs_req_latch.sv
module mcs_req_latch #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          wr_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assert_hold_without_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(accept) |-> ($stable(addr_q) && $stable(wr_q) && $stable(wdata_q)));

endmodule

// File: rtl/mcs_bus_drive.sv
module mcs_bus_drive #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          active,
  input  logic          phase_first,
  input  logic          wr_q,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] wdata_q,
  output logic [AW-1:0] mem_addr,
  output logic          mem_en,
  output logic          mem_rw,
  output logic [DW-1:0] mem_wdata
);

  logic strobe_phase;
  assign strobe_phase = active && !phase_first;  // T2..TN

  always_comb begin
    mem_addr  = addr_q;
    mem_en    = active;
    mem_rw    = 1'b1;
    mem_wdata = '0;
    if (strobe_phase && wr_q) begin
      mem_rw    = 1'b0;
      mem_wdata = wdata_q;
    end
  end

endmodule

// File: rtl/mcs_rd_capture.sv
module mcs_rd_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase_last,
  input  logic          wr_q,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] rd_data,
  output logic          done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= phase_last;
      if (phase_last && !wr_q) begin
        rd_data <= mem_rdata;
      end
    end
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/mem_cycle_seq.sv
module mem_cycle_seq #(
  parameter int AW        = 10,
  parameter int DW        = 16,
  parameter int PERIOD_NS = 20,
  parameter int ACCESS_NS = 65,
  parameter int WRITE_NS  = 75
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_en,
  output logic          mem_rw,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam int NUM_PHASES = mcs_pkg::phase_count(PERIOD_NS, ACCESS_NS, WRITE_NS);
  localparam int PW         = $clog2(NUM_PHASES + 1);

  // named internal events
  logic          accept;
  logic          active;
  logic          phase_first;
  logic          phase_last;
  logic [PW-1:0] phase;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  assign req_ready = !active;
  assign busy      = active;
  assign accept    = req_valid && req_ready;

  mcs_phase_ctrl #(.NUM_PHASES(NUM_PHASES)) phase_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .phase(phase),
    .phase_first(phase_first), .phase_last(phase_last), .active(active)
  );

  mcs_req_latch #(.AW(AW), .DW(DW)) latch_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .wr_q(wr_q), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  mcs_bus_drive #(.AW(AW), .DW(DW)) drive_i (
    .active(active), .phase_first(phase_first), .wr_q(wr_q),
    .addr_q(addr_q), .wdata_q(wdata_q), .mem_addr(mem_addr),
    .mem_en(mem_en), .mem_rw(mem_rw), .mem_wdata(mem_wdata)
  );

  mcs_rd_capture #(.DW(DW)) capture_i (
    .clk(clk), .rst_n(rst_n), .phase_last(phase_last), .wr_q(wr_q),
    .mem_rdata(mem_rdata), .rd_data(rd_data), .done(done)
  );

  assert_accept_starts_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mem_en && phase_first));

  assert_t1_read_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_en) |-> (mem_rw && (mem_wdata == '0)));

  assert_write_after_t1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rw) |-> (mem_en && $past(mem_en)));

  assert_addr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !phase_first) |-> $stable(mem_addr));

  assert_idle_safe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en |-> (mem_rw && (mem_wdata == '0)));

  assert_done_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_en && $past(mem_en)));

endmodule

// File: tb/mem_cycle_seq_tb_top.sv
module mem_cycle_seq_tb_top;

  localparam int CLK_PERIOD_NS = 20;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam int EXP_PHASES = (75 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int RD_CYC = (65 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int WR_CYC = EXP_PHASES;
  localparam logic [DW-1:0] NOT_READY = 16'hDEAD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, busy, done, mem_en, mem_rw;
  logic [DW-1:0] rd_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD_NS/2) clk = ~clk;

  mem_cycle_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .busy(busy), .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_en(mem_en), .mem_rw(mem_rw), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // behavioural memory with delays counted in clocks
  logic [DW-1:0] mem_arr [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  int en_cnt = 0;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_arr[i] = DW'(i * 7 + 3);
      shadow[i]  = DW'(i * 7 + 3);
    end
  end

  always @(posedge clk) begin
    if (mem_en && !mem_rw && en_cnt == WR_CYC - 1) mem_arr[mem_addr] <= mem_wdata;
    en_cnt <= mem_en ? en_cnt + 1 : 0;
  end

  assign mem_rdata = (mem_en && mem_rw && en_cnt >= RD_CYC - 1) ? mem_arr[mem_addr] : NOT_READY;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  bit            q_is_read [$];
  logic [DW-1:0] q_value   [$];
  logic [DW-1:0] last_read = '0;

  // bus expectations for the running cycle
  bit            cur_wr = 1'b0;
  logic [AW-1:0] cur_addr = '0;
  logic [DW-1:0] cur_data = '0;
  int            en_len = 0;

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    cur_wr = wr; cur_addr = a; cur_data = d;
    q_is_read.push_back(!wr);
    if (wr) begin
      shadow[a] = d;
      q_value.push_back('0);
    end else begin
      q_value.push_back(shadow[a]);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: results and bus phases
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (q_is_read.size() == 0) begin
          check("R2 unexpected done", 1, 0);
        end else begin
          bit is_rd;
          logic [DW-1:0] v;
          is_rd = q_is_read.pop_front();
          v = q_value.pop_front();
          if (is_rd) begin
            check("R5 read data", rd_data, v);
            last_read = v;
          end else begin
            check("R7 rd_data kept after write", rd_data, last_read);
          end
        end
      end
      if (mem_en) begin
        en_len++;
        check("R2 ready low while busy", {busy, req_ready}, 2'b10);
        check("R3 address", mem_addr, cur_addr);
        if (en_len == 1) begin
          check("R3 T1 rw high", mem_rw, 1);
          check("R3 T1 wdata zero", mem_wdata, 0);
        end else if (cur_wr) begin
          check("R4 write select", mem_rw, 0);
          check("R4 write data", mem_wdata, cur_data);
        end else begin
          check("R5 read select", mem_rw, 1);
        end
      end else begin
        if (en_len != 0) check("R8 phase count", en_len, EXP_PHASES);
        en_len = 0;
        check("R9 idle bus", {mem_rw, mem_wdata}, {1'b1, 16'h0});
      end
      if (done) check("R7 done in idle cycle", mem_en, 0);
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD_NS * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ready/busy/done", {req_ready, busy, done}, 3'b100);
    check("R1 reset bus", {mem_en, mem_rw}, 2'b01);
    check("R1 reset rd_data", rd_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    issue(1'b0, 10'd0, '0);
    issue(1'b0, 10'd1023, '0);
    issue(1'b1, 10'd5, 16'h1234);
    issue(1'b0, 10'd5, '0);
    issue(1'b1, 10'd1023, 16'hFFFF);
    issue(1'b0, 10'd1023, '0);
    issue(1'b1, 10'd0, 16'h0000);
    issue(1'b0, 10'd0, '0);
    issue(1'b0, 10'd512, '0);

    // R2/R6: stray request during a running read
    issue(1'b0, 10'd77, '0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 10'd300; req_wdata = 16'hBEEF;
    repeat (2) @(negedge clk);
    check("R6 address held against stray request", mem_addr, 10'd77);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    issue(1'b0, 10'd300, '0);  // must still hold the original word

    // back-to-back mixed traffic
    for (int k = 0; k < 8; k++) begin
      issue(k[0], AW'(k * 131), DW'(16'hA500 + k));
    end
    issue(1'b0, 10'd262, '0);

    repeat (EXP_PHASES + 4) @(negedge clk);
    check("R7 all results delivered", q_is_read.size(), 0);
    check("R9 final idle", {mem_en, req_ready}, 2'b01);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule